// File: doc/BRIEF.md
# Multiport Buffered Memory Arbiter

This block lets a set of streaming write ports and streaming read ports share one single-ported word memory. Each port behaves like a small DMA channel. Software programs a start address, a word count and an address step, then starts the channel. A write port takes words from its stream into a local buffer. A read port fetches words from memory into its local buffer and hands them to its stream consumer.

Only one port can use the memory at a time. A scheduler hands the memory to one port for a burst of up to `BURST` words. A port is considered only when its buffer can make a worthwhile burst: a write buffer that is at least half full, or a read buffer with at least half of its space free. Near the end of a transfer a smaller burst is allowed, so that the last words are not left behind. A stream that arrives while another port holds the memory is not stalled. Its words collect in its buffer until its turn comes, so all streams advance nearly together.

Each channel has a sticky completion flag that software polls and clears by writing 1. The memory side is a plain request/grant word interface with wait states. DRAM command sequencing and refresh belong to a separate controller.

Top module: `mpm_arbiter`

## Requirements
- R1: A write port raises `wr_ready_o` only while its channel is busy, its buffer (`DEPTH` words) is not full, and fewer than the programmed count of words have been accepted. With the memory withheld, exactly `DEPTH` words are taken and ready then stays low.
- R2: A read port raises `rd_valid_o` only while its buffer holds a word. Words leave in the order they were fetched.
- R3: Channel word i goes to or comes from address base + i*stride, modulo 2^AW, in increasing i.
- R4: At most one port drives the memory at a time, and only while its channel is busy. A single grant covers at most `BURST` words. One word moves in each cycle where `mem_req_o` and `mem_gnt_i` are both high. Read data is taken from `mem_rdata_i` in that same cycle.
- R5: Ports that qualify are served round-robin. When a burst ends and another port qualifies, the next grant goes to a different port.
- R6: A write port qualifies in either of two cases: its buffer holds at least `BURST` words, or its buffer holds every word still owed to memory and that number is nonzero. This second case flushes a final partial burst.
- R7: A read port qualifies when words remain to fetch and its free space is at least `BURST` or at least the remaining count. While its consumer is stalled, it fetches no more than `DEPTH` words, stops requesting, and stays busy.
- R8: CSR address = {port index, select}. Write ports take the lower indices and read ports follow them. The select field in bits [1:0] chooses base (0), count (1), stride (2) or control (3). Writing control bit 0 = 1 starts the channel. Reading control bit 0 gives the busy state. A start while busy is ignored, and so is any register change for the running transfer. A count of 0 completes at once.
- R9: Control bit 1 is the done flag. It is set when the last word of the transfer has moved to or from memory. It stays set until software writes 1 to bit 1.
- R10: After reset, no memory request is made, no write ready or read valid is raised, and every CSR reads 0.
- R11: Every written word lands at its own address. Addresses that the stride skips over keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | $clog2(NW+NR)+2 | CSR address {port, select} |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| wr_valid_i | input | NW | Write stream valid per port |
| wr_data_i | input | NW*DW | Write stream data, port p at [p*DW +: DW] |
| wr_ready_o | output | NW | Write stream ready per port |
| rd_valid_o | output | NR | Read stream valid per port |
| rd_data_o | output | NR*DW | Read stream data, port r at [r*DW +: DW] |
| rd_ready_i | input | NR | Read stream ready per port |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_gnt_i | input | 1 | Memory accepts the word this cycle |
| mem_rdata_i | input | DW | Read data, valid in the grant cycle |

## Verification
Some rules are checked on every cycle by properties: buffers never overflow or underflow, each accepted word advances the address by the stride, a burst never exceeds `BURST` words, requests come only from a busy owner, grants follow the qualification thresholds and rotate away from the last owner, and done stays set until cleared. Other behaviour is visible only from the bench scenarios, where several streams run at once under random memory wait states. These show that every word ends up at its own address in order, that skipped addresses are left alone, that a final partial burst is flushed, that a withheld memory fills a write buffer to exactly its depth, that a stalled reader stops fetching, and that a start is ignored while the channel is busy.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_STRIDE = 2'd2,
    SEL_CTRL   = 2'd3
  } csr_sel_e;

  localparam int unsigned CTRL_GO_BIT   = 0;
  localparam int unsigned CTRL_DONE_BIT = 1;
endpackage

// File: rtl/mpm_fifo.sv
module mpm_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [FW-1:0] fill_o
);
  logic [DW-1:0] store_q [DEPTH];
  logic [LW-1:0] wp_q, rp_q;
  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) store_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == LW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == LW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = store_q[rp_q];
  assign full_o  = (cnt_q == FW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign fill_o  = cnt_q;

  // R1
  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R2
  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/mpm_agen.sv
module mpm_agen #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] stride_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] rem_o
);
  logic [AW-1:0] stride_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      rem_o    <= '0;
      stride_q <= '0;
    end else if (start_i) begin
      addr_o   <= base_i;
      rem_o    <= count_i;
      stride_q <= stride_i;
    end else if (step_i && rem_o != '0) begin
      addr_o <= addr_o + stride_q;
      rem_o  <= rem_o - 1'b1;
    end
  end

  // R3
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && rem_o != '0 && !start_i) |=> (addr_o == $past(addr_o) + $past(stride_q)));
endmodule

// File: rtl/mpm_sched.sv
module mpm_sched #(
  parameter int NP    = 4,
  parameter int BURST = 4,
  localparam int PW   = (NP > 1) ? $clog2(NP) : 1,
  localparam int BW   = $clog2(BURST + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] elig_i,
  input  logic          beat_i,
  input  logic          last_i,
  output logic          active_o,
  output logic [PW-1:0] owner_o,
  output logic          start_o,
  output logic [PW-1:0] pick_o
);
  logic [PW-1:0] last_q;
  logic [BW-1:0] beats_q;
  logic          pick_vld;

  always_comb begin
    pick_vld = 1'b0;
    pick_o   = last_q;
    for (int k = 1; k <= NP; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NP;
      if (!pick_vld && elig_i[idx]) begin
        pick_vld = 1'b1;
        pick_o   = PW'(idx);
      end
    end
  end

  assign start_o = !active_o && pick_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      owner_o  <= '0;
      last_q   <= PW'(NP - 1);
      beats_q  <= '0;
    end else if (start_o) begin
      active_o <= 1'b1;
      owner_o  <= pick_o;
      last_q   <= pick_o;
      beats_q  <= '0;
    end else if (active_o && beat_i) begin
      beats_q <= beats_q + 1'b1;
      if (beats_q == BW'(BURST - 1) || last_i) active_o <= 1'b0;
    end
  end

  // R4
  p_burst_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (beats_q < BW'(BURST)));
  // R5
  p_rr_rotate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && |(elig_i & ~(NP'(1) << last_q))) |-> (pick_o != last_q));
endmodule

// File: rtl/mpm_arbiter.sv
module mpm_arbiter
  import mpm_pkg::*;
#(
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 8,
  parameter int BURST = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          csr_we_i,
  input  logic [$clog2(NW+NR)+1:0]      csr_addr_i,
  input  logic [31:0]                   csr_wdata_i,
  output logic [31:0]                   csr_rdata_o,
  input  logic [NW-1:0]                 wr_valid_i,
  input  logic [NW*DW-1:0]              wr_data_i,
  output logic [NW-1:0]                 wr_ready_o,
  output logic [NR-1:0]                 rd_valid_o,
  output logic [NR*DW-1:0]              rd_data_o,
  input  logic [NR-1:0]                 rd_ready_i,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [AW-1:0]                 mem_addr_o,
  output logic [DW-1:0]                 mem_wdata_o,
  input  logic                          mem_gnt_i,
  input  logic [DW-1:0]                 mem_rdata_i
);
  localparam int NP     = NW + NR;
  localparam int PW     = $clog2(NP);
  localparam int CSR_AW = PW + 2;
  localparam int FW     = $clog2(DEPTH + 1);

  logic [AW-1:0]    base_q   [NP];
  logic [AW-1:0]    stride_q [NP];
  logic [CNT_W-1:0] cnt_q    [NP];
  logic [CNT_W-1:0] acc_q    [NW];
  logic [NP-1:0]    busy_q, done_q, start, clr, finish, elig, beat;
  logic [NP-1:0]    push, pop, full, empty;
  logic [AW-1:0]    addr [NP];
  logic [CNT_W-1:0] rem  [NP];
  logic [FW-1:0]    fill [NP];
  logic [DW-1:0]    head [NP];
  logic [DW-1:0]    fifo_wdata [NP];

  csr_sel_e         sel;
  logic [PW-1:0]    pidx;
  logic             sched_active, sched_start;
  logic [PW-1:0]    owner, sched_pick;
  logic             owner_is_wr, owner_last;
  logic             unused_bits;

  assign sel         = csr_sel_e'(csr_addr_i[1:0]);
  assign pidx        = csr_addr_i[CSR_AW-1:2];
  assign unused_bits = ^csr_wdata_i;

  // CSR decode
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      start[p]  = csr_we_i && pidx == PW'(p) && sel == SEL_CTRL
                  && csr_wdata_i[CTRL_GO_BIT] && !busy_q[p];
      clr[p]    = csr_we_i && pidx == PW'(p) && sel == SEL_CTRL
                  && csr_wdata_i[CTRL_DONE_BIT];
      finish[p] = busy_q[p] && rem[p] == '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      done_q <= '0;
      for (int p = 0; p < NP; p++) begin
        base_q[p]   <= '0;
        stride_q[p] <= '0;
        cnt_q[p]    <= '0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (csr_we_i && pidx == PW'(p)) begin
          case (sel)
            SEL_BASE:   base_q[p]   <= csr_wdata_i[AW-1:0];
            SEL_COUNT:  cnt_q[p]    <= csr_wdata_i[CNT_W-1:0];
            SEL_STRIDE: stride_q[p] <= csr_wdata_i[AW-1:0];
            default: ;
          endcase
        end
        if (start[p])       busy_q[p] <= 1'b1;
        else if (finish[p]) busy_q[p] <= 1'b0;
        if (finish[p])      done_q[p] <= 1'b1;
        else if (clr[p])    done_q[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NW; p++) acc_q[p] <= '0;
    end else begin
      for (int p = 0; p < NW; p++) begin
        if (start[p])     acc_q[p] <= cnt_q[p];
        else if (push[p]) acc_q[p] <= acc_q[p] - 1'b1;
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    for (int p = 0; p < NP; p++) begin
      if (pidx == PW'(p)) begin
        case (sel)
          SEL_BASE:   csr_rdata_o = 32'(base_q[p]);
          SEL_COUNT:  csr_rdata_o = 32'(cnt_q[p]);
          SEL_STRIDE: csr_rdata_o = 32'(stride_q[p]);
          default: begin
            csr_rdata_o[CTRL_GO_BIT]   = busy_q[p];
            csr_rdata_o[CTRL_DONE_BIT] = done_q[p];
          end
        endcase
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    mpm_agen #(.AW(AW), .CW(CNT_W)) u_agen (
      .clk_i, .rst_ni,
      .start_i (start[p]),
      .base_i  (base_q[p]),
      .count_i (cnt_q[p]),
      .stride_i(stride_q[p]),
      .step_i  (beat[p]),
      .addr_o  (addr[p]),
      .rem_o   (rem[p])
    );

    mpm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk_i, .rst_ni,
      .push_i (push[p]),
      .wdata_i(fifo_wdata[p]),
      .pop_i  (pop[p]),
      .rdata_o(head[p]),
      .full_o (full[p]),
      .empty_o(empty[p]),
      .fill_o (fill[p])
    );

    if (p < NW) begin : g_wr
      assign wr_ready_o[p]  = busy_q[p] && !full[p] && acc_q[p] != '0;
      assign push[p]        = wr_valid_i[p] && wr_ready_o[p];
      assign fifo_wdata[p]  = wr_data_i[p*DW +: DW];
      assign pop[p]         = beat[p];
      assign elig[p]        = busy_q[p] && fill[p] != '0
                              && (fill[p] >= FW'(BURST) || CNT_W'(fill[p]) == rem[p]);

      // R6
      p_wr_thresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sched_start && sched_pick == PW'(p))
          |-> (fill[p] >= FW'(BURST) || (fill[p] != '0 && CNT_W'(fill[p]) == rem[p])));
    end else begin : g_rd
      localparam int R = p - NW;
      logic [FW-1:0] free;
      assign free          = FW'(DEPTH) - fill[p];
      assign push[p]       = beat[p];
      assign fifo_wdata[p] = mem_rdata_i;
      assign pop[p]        = rd_valid_o[R] && rd_ready_i[R];
      assign rd_valid_o[R] = !empty[p];
      assign rd_data_o[R*DW +: DW] = head[p];
      assign elig[p]       = busy_q[p] && rem[p] != '0 && free != '0
                             && (free >= FW'(BURST) || CNT_W'(free) >= rem[p]);

      // R7
      p_rd_space_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sched_start && sched_pick == PW'(p))
          |-> (free >= FW'(BURST) || (free != '0 && CNT_W'(free) >= rem[p])));
    end

    // R9
    p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q[p] && !clr[p]) |=> done_q[p]);
  end

  mpm_sched #(.NP(NP), .BURST(BURST)) u_sched (
    .clk_i, .rst_ni,
    .elig_i  (elig),
    .beat_i  (mem_req_o && mem_gnt_i),
    .last_i  (owner_last),
    .active_o(sched_active),
    .owner_o (owner),
    .start_o (sched_start),
    .pick_o  (sched_pick)
  );

  assign owner_is_wr = int'(owner) < NW;
  assign owner_last  = rem[owner] == CNT_W'(1);
  assign mem_req_o   = sched_active && rem[owner] != '0
                       && (owner_is_wr ? !empty[owner] : !full[owner]);
  assign mem_we_o    = owner_is_wr;
  assign mem_addr_o  = addr[owner];
  assign mem_wdata_o = head[owner];

  always_comb begin
    for (int p = 0; p < NP; p++) beat[p] = mem_req_o && mem_gnt_i && owner == PW'(p);
  end

  // R4
  p_req_owner_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_q[owner]);
  // R4
  p_single_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(beat) <= 1);
endmodule

// File: tb/mpm_arbiter_test.sv
`timescale 1ns/1ps
module mpm_arbiter_test;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [1:0]  wr_valid, wr_ready, rd_valid;
  logic [63:0] wr_data, rd_data;
  logic [1:0]  rd_rdy = 2'b00;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  logic [31:0] model [512];
  int n_chk = 0, n_fail = 0;
  int wr_idx [2], wr_tot [2], rd_cnt [2], rd_err [2], rbase [2], rstride [2];
  int switches;
  logic [2:0] prev_reg;
  bit wr_on = 1'b0, src_clr = 1'b0, gnt_off = 1'b0;
  int tag_q = 0;

  // CSR selects
  localparam int S_BASE = 0, S_CNT = 1, S_STR = 2, S_CTRL = 3;

  // rows: count[31:24] stride[23:16] offset[15:8] tag[7:0]
  localparam logic [31:0] ROWS [4] = '{
    {8'd8,  8'd1, 8'd40, 8'd1},
    {8'd5,  8'd2, 8'd0,  8'd2},
    {8'd12, 8'd3, 8'd10, 8'd3},
    {8'd1,  8'd4, 8'd50, 8'd4}
  };

  mpm_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_ready_i(rd_rdy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] wpat(int p, int tag, int i);
    return {8'(160 + p), 8'(tag), 16'(i)};
  endfunction

  function automatic logic [31:0] rpat(int a);
    return 32'hC0DE0000 | 32'(a);
  endfunction

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      wr_valid[p]        = wr_on && wr_idx[p] < wr_tot[p];
      wr_data[p*32 +: 32] = wpat(p, tag_q, wr_idx[p]);
    end
  end

  // memory model: grant and read data decided away from the edge
  always @(negedge clk) begin
    mem_gnt   = mem_req && !gnt_off && ($urandom_range(2, 0) != 0);
    mem_rdata = model[mem_addr[8:0]];
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) model[mem_addr[8:0]] <= mem_wdata;
    for (int p = 0; p < 2; p++) begin
      if (src_clr) wr_idx[p] <= 0;
      else if (wr_valid[p] && wr_ready[p]) wr_idx[p] <= wr_idx[p] + 1;
      if (src_clr) begin
        rd_cnt[p] <= 0;
        rd_err[p] <= 0;
      end else if (rd_valid[p] && rd_rdy[p]) begin
        if (rd_data[p*32 +: 32] != rpat(rbase[p] + rd_cnt[p] * rstride[p])) rd_err[p] <= rd_err[p] + 1;
        rd_cnt[p] <= rd_cnt[p] + 1;
      end
    end
    if (src_clr) switches <= 0;
    else if (mem_req && mem_gnt) begin
      if (mem_addr[8:6] != prev_reg) switches <= switches + 1;
      prev_reg <= mem_addr[8:6];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input int p, input int s, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = {2'(p), 2'(s)}; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input int p, input int s, output logic [31:0] d);
    @(negedge clk);
    csr_addr = {2'(p), 2'(s)};
    #1 d = csr_rdata;
  endtask

  task automatic cfg(input int p, input int base, input int cnt, input int st);
    csr_wr(p, S_BASE, 32'(base));
    csr_wr(p, S_CNT, 32'(cnt));
    csr_wr(p, S_STR, 32'(st));
  endtask

  task automatic pulse_clr();
    @(negedge clk); src_clr = 1'b1;
    @(negedge clk); src_clr = 1'b0;
  endtask

  task automatic wait_done(input logic [3:0] mask);
    logic [31:0] v;
    for (int it = 0; it < 4000; it++) begin
      bit all = 1'b1;
      for (int p = 0; p < 4; p++) if (mask[p]) begin
        csr_rd(p, S_CTRL, v);
        if (!v[1]) all = 1'b0;
      end
      if (all) break;
    end
  endtask

  task automatic run_row(input logic [31:0] row);
    int cnt, st, off, tag;
    logic [31:0] v;
    cnt = int'(row[31:24]); st = int'(row[23:16]); off = int'(row[15:8]); tag = int'(row[7:0]);
    pulse_clr();
    tag_q = tag;
    for (int p = 0; p < 2; p++) begin
      wr_tot[p]  = cnt;
      rbase[p]   = 128 + p * 64 + off;
      rstride[p] = st;
    end
    wr_on = 1'b1; rd_rdy = 2'b11;
    for (int p = 0; p < 2; p++) cfg(p, p * 64 + off, cnt, st);
    for (int p = 0; p < 2; p++) cfg(2 + p, rbase[p], cnt, st);
    for (int p = 0; p < 4; p++) csr_wr(p, S_CTRL, 32'h1);
    wait_done(4'hF);
    repeat (20) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      int bad = 0;
      for (int i = 0; i < cnt; i++)
        if (model[p * 64 + off + i * st] != wpat(p, tag, i)) bad++;
      check(bad == 0, "R3/R11 write words at base+i*stride", 32'(bad), 0);
      if (st > 1) check(model[p * 64 + off + 1] == rpat(p * 64 + off + 1), "R11 skipped address kept",
                        model[p * 64 + off + 1], rpat(p * 64 + off + 1));
      check(rd_cnt[p] == cnt && rd_err[p] == 0, "R2/R3 read stream order and count",
            32'(rd_cnt[p] * 256 + rd_err[p]), 32'(cnt * 256));
    end
    if (cnt == 5) check(model[2 * 4] == wpat(0, tag, 4), "R6 final partial burst flushed", model[8], wpat(0, tag, 4));
    if (cnt == 12) check(switches >= 3, "R5 round-robin interleaving", 32'(switches), 3);
    for (int p = 0; p < 4; p++) begin
      csr_rd(p, S_CTRL, v);
      check(v == 32'h2, "R9 done set and busy clear", v, 32'h2);
      csr_wr(p, S_CTRL, 32'h2);
      csr_rd(p, S_CTRL, v);
      check(v == 32'h0, "R9 done cleared by writing 1", v, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 512; i++) model[i] = rpat(i);
    for (int p = 0; p < 2; p++) begin
      wr_idx[p] = 0; wr_tot[p] = 0; rd_cnt[p] = 0; rd_err[p] = 0; rbase[p] = 0; rstride[p] = 1;
    end
    switches = 0; prev_reg = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(mem_req == 1'b0, "R10 no request in reset", 32'(mem_req), 0);
    check(wr_ready == 2'b00, "R10 write ready low", 32'(wr_ready), 0);
    check(rd_valid == 2'b00, "R10 read valid low", 32'(rd_valid), 0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      csr_rd(p, S_CTRL, v); check(v == 0, "R10 control reads 0", v, 0);
      csr_rd(p, S_BASE, v); check(v == 0, "R10 base reads 0", v, 0);
    end

    for (int k = 0; k < 4; k++) run_row(ROWS[k]);

    // R1: memory withheld, buffer takes exactly DEPTH words
    pulse_clr();
    tag_q = 9; wr_tot[1] = 12; wr_on = 1'b1; gnt_off = 1'b1;
    cfg(1, 64, 12, 1);
    csr_wr(1, S_CTRL, 32'h1);
    repeat (30) @(negedge clk);
    check(wr_idx[1] == 8, "R1 words accepted with memory withheld", 32'(wr_idx[1]), 8);
    check(wr_ready[1] == 1'b0, "R1 ready low when buffer full", 32'(wr_ready[1]), 0);
    gnt_off = 1'b0;
    wait_done(4'b0010);
    begin
      int bad = 0;
      for (int i = 0; i < 12; i++) if (model[64 + i] != wpat(1, 9, i)) bad++;
      check(bad == 0, "R1 all words after release", 32'(bad), 0);
    end
    check(wr_ready[1] == 1'b0, "R1 ready low once count accepted", 32'(wr_ready[1]), 0);
    csr_wr(1, S_CTRL, 32'h2);

    // R8: start ignored while busy
    pulse_clr();
    wr_on = 1'b0; tag_q = 10; wr_tot[0] = 3;
    cfg(0, 56, 3, 1);
    csr_wr(0, S_CTRL, 32'h1);
    csr_wr(0, S_BASE, 32'd60);
    csr_wr(0, S_CTRL, 32'h1);
    csr_rd(0, S_CTRL, v);
    check(v == 32'h1, "R8 control reads busy", v, 32'h1);
    check(wr_ready[0] == 1'b1, "R1 ready while busy and empty", 32'(wr_ready[0]), 1);
    wr_on = 1'b1;
    wait_done(4'b0001);
    repeat (5) @(negedge clk);
    check(model[56] == wpat(0, 10, 0) && model[58] == wpat(0, 10, 2), "R8 first start's base used",
          model[58], wpat(0, 10, 2));
    check(model[60] == rpat(60), "R8 second start ignored", model[60], rpat(60));
    csr_wr(0, S_CTRL, 32'h2);

    // R7: stalled reader stops fetching and stays busy
    pulse_clr();
    rd_rdy = 2'b00; rbase[0] = 128; rstride[0] = 1;
    cfg(2, 128, 12, 1);
    csr_wr(2, S_CTRL, 32'h1);
    repeat (80) @(negedge clk);
    csr_rd(2, S_CTRL, v);
    check(v == 32'h1, "R7 stalled read stays busy", v, 32'h1);
    check(mem_req == 1'b0, "R7 fetch stops at buffer depth", 32'(mem_req), 0);
    check(rd_valid[0] == 1'b1, "R2 valid with buffered words", 32'(rd_valid[0]), 1);
    rd_rdy = 2'b11;
    wait_done(4'b0100);
    repeat (20) @(negedge clk);
    check(rd_cnt[0] == 12 && rd_err[0] == 0, "R7 all words after release",
          32'(rd_cnt[0] * 256 + rd_err[0]), 32'(12 * 256));
    check(rd_valid[0] == 1'b0, "R2 valid low when drained", 32'(rd_valid[0]), 0);
    csr_wr(2, S_CTRL, 32'h2);

    // R8: zero count completes at once
    cfg(3, 200, 0, 1);
    csr_wr(3, S_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    csr_rd(3, S_CTRL, v);
    check(v == 32'h2, "R8 zero count completes", v, 32'h2);
    check(rd_valid[1] == 1'b0, "R8 zero count delivers nothing", 32'(rd_valid[1]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule